// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences the backplane and segment drive levels of a passive LCD with up to four backplanes and a parameterised number of segment lines (40 by default). Each output gets a 2-bit level code every cycle. A separate analog stage turns that code into one of the bias voltages. The inputs are the display-data bits and a small set of control fields: multiplex ratio, bias scheme, display enable, frame rate, blink rate and polarity-inversion style.

A single-cycle reference tick arrives at nominally 2048 Hz. A fractional accumulator driven by this tick produces slot steps at the chosen frame rate × 2 × (number of multiplexed backplanes). Each frame holds one positive and one negative slot per backplane, so every cell sees zero net DC. Changes to the multiplex ratio, the bias or the inversion style are shadowed and take effect only at a frame boundary. A free-running counter of reference ticks blanks the segments for half of each blink period.

Top module: `lcd_drive_seq`

## Requirements
- R1: When `disp_en` is 0, every backplane and segment output carries code 0 (VSS), and the slot, accumulator and blink counters return to 0. After reset the outputs are all 0.
- R2: Level codes are 0 = VSS, 1 = lower intermediate (VLCD/3, or VLCD/2 under half bias), 2 = 2VLCD/3, 3 = VLCD. Under one-third bias in a positive slot:
  - the selected backplane is at 3 and unselected backplanes are at 1;
  - an on segment is at 0 and an off segment is at 2.
  - A negative slot maps every code c to 3−c.
- R3: With `half_bias`=1 in a multiplexed mode:
  - a positive slot puts the selected backplane at 3, unselected backplanes at 1, on segments at 0 and off segments at 1;
  - a negative slot maps 0↔3 and leaves 1 unchanged.
  - Code 2 never appears.
- R4: In static mode (`mux_sel`=11) `half_bias` is ignored. All backplanes are at 3 in the positive slot and at 0 in the negative slot. An on segment takes the opposite level and an off segment takes the same level.
- R5: Display bit `pix[r*SEGS+s]` belongs to backplane row r and segment s. A 1 turns that element on, and a segment follows the row of the currently selected backplane.
- R6: The `mux_sel` encoding is 00 = 4 backplanes, 01 = 3, 10 = 2, 11 = 1. With `frame_inv`=0 the slots of a frame run: row0+, row0−, row1+, row1−, and so on.
- R7: With `frame_inv`=1 the first n slots select rows 0..n−1 with positive polarity and the next n slots select the same rows with negative polarity.
- R8: In the 3-backplane mode COM3 copies COM1. In the 2-backplane mode COM2 copies COM0 and COM3 copies COM1. In static mode all four backplanes match.
- R9: On each reference tick while enabled, the accumulator adds (`frame_rate`+1)×n. When the sum reaches 32, the slot advances and 32 is subtracted. The slot wraps to 0 after slot 2n−1. Without a tick the slot holds.
- R10: Blink codes are 01 = 0.5 Hz, 10 = 1 Hz, 11 = 2 Hz, 00 = off. Bit 11, 10 or 9 of the 12-bit reference-tick counter, respectively, marks the blank half. During the blank half every segment is driven at its off level while the backplanes keep running.
- R11: `mux_sel`, `half_bias` and `frame_inv` are sampled only on the tick that wraps the frame to slot 0, or while the display is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle reference pulse (nominally 2048 Hz) |
| disp_en | input | 1 | Display enable |
| mux_sel | input | 2 | Multiplex ratio select |
| half_bias | input | 1 | 1 = half bias, 0 = one-third bias |
| frame_inv | input | 1 | 1 = frame-wise polarity inversion, 0 = slot-wise |
| frame_rate | input | 2 | Frame rate select, 32 Hz × (value+1) |
| blink_rate | input | 2 | Blink rate select |
| pix | input | 4*SEGS | Display data, row-major |
| com_lvl | output | 8 | Backplane level codes, 2 bits per backplane |
| seg_lvl | output | 2*SEGS | Segment level codes, 2 bits per segment |

## Verification
A configuration change can arrive in the same cycle as the tick that wraps the frame. The bench provokes this by rewriting the bias, ratio and inversion fields mid-frame while ticks arrive every cycle. Because of this, a fresh value is present on the wrapping edge. A blink blank-out transition can also coincide with a slot step, since both are counted from the same tick. Every cycle is judged against a model, built from the requirements, of which configuration governs the next frame and which segments are blanked.

// File: rtl/lcd_drive_seq.sv
module lcd_drive_seq #(
  parameter int SEGS    = 40,
  parameter int ACC_MOD = 32,
  parameter int BLINK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              disp_en,
  input  logic [1:0]        mux_sel,
  input  logic              half_bias,
  input  logic              frame_inv,
  input  logic [1:0]        frame_rate,
  input  logic [1:0]        blink_rate,
  input  logic [4*SEGS-1:0] pix,
  output logic [7:0]        com_lvl,
  output logic [2*SEGS-1:0] seg_lvl
);
  localparam int AW = $clog2(2*ACC_MOD);

  logic [2:0]         slot;
  logic [AW-1:0]      acc;
  logic [BLINK_W-1:0] blink;
  logic [1:0]         a_mux;
  logic               a_half, a_inv;

  logic [2:0]    nmux;
  logic [3:0]    nslots;
  logic [AW-1:0] sum;
  logic          wrap;
  int            step_i;

  always_comb
    case (a_mux)
      2'd0: nmux = 3'd4;
      2'd1: nmux = 3'd3;
      2'd2: nmux = 3'd2;
      default: nmux = 3'd1;
    endcase

  assign nslots = {nmux, 1'b0};
  assign step_i = (int'(frame_rate) + 1) * int'(nmux);
  assign sum    = acc + AW'(step_i);
  assign wrap   = ({1'b0, slot} == nslots - 4'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot <= '0; acc <= '0; blink <= '0;
      a_mux <= '0; a_half <= 1'b0; a_inv <= 1'b0;
    end else if (!disp_en) begin
      slot <= '0; acc <= '0; blink <= '0;
      a_mux <= mux_sel; a_half <= half_bias; a_inv <= frame_inv;
    end else if (ref_tick) begin
      blink <= blink + 1'b1;
      if (sum >= AW'(ACC_MOD)) begin
        acc <= sum - AW'(ACC_MOD);
        if (wrap) begin
          slot <= '0;
          a_mux <= mux_sel; a_half <= half_bias; a_inv <= frame_inv;
        end else
          slot <= slot + 3'd1;
      end else
        acc <= sum;
    end

  logic [1:0]      sel;
  logic            neg, stat, hb, blank;
  logic [SEGS-1:0] row;

  always_comb
    if (a_inv) begin
      if (slot >= nmux) begin sel = 2'(slot - nmux); neg = 1'b1; end
      else              begin sel = 2'(slot);        neg = 1'b0; end
    end else begin
      sel = slot[2:1]; neg = slot[0];
    end

  always_comb
    case (blink_rate)
      2'd1: blank = blink[BLINK_W-1];
      2'd2: blank = blink[BLINK_W-2];
      2'd3: blank = blink[BLINK_W-3];
      default: blank = 1'b0;
    endcase

  assign stat = (a_mux == 2'd3);
  assign hb   = a_half && !stat;
  assign row  = pix[sel*SEGS +: SEGS];

  function automatic logic [1:0] flip(input logic [1:0] c, input logic n, input logic h);
    if (!n) return c;
    if (h && c == 2'd1) return c;
    return ~c;
  endfunction

  always_comb begin
    logic [1:0] l;
    com_lvl = '0;
    for (int p = 0; p < 4; p++) begin
      case (a_mux)
        2'd0: l = 2'(p);
        2'd1: l = (p == 3) ? 2'd1 : 2'(p);
        2'd2: l = 2'(p % 2);
        default: l = 2'd0;
      endcase
      if (disp_en) com_lvl[2*p +: 2] = flip((l == sel) ? 2'd3 : 2'd1, neg, hb);
    end
  end

  always_comb begin
    logic [1:0] c;
    seg_lvl = '0;
    for (int s = 0; s < SEGS; s++) begin
      if (row[s] && !blank) c = 2'd0;
      else c = stat ? 2'd3 : (hb ? 2'd1 : 2'd2);
      if (disp_en) seg_lvl[2*s +: 2] = flip(c, neg, hb);
    end
  end

  a_r1_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (com_lvl == '0 && seg_lvl == '0))
    else $error("R1 outputs not dark while disabled");

  a_r6_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, slot} < nslots))
    else $error("R6 slot beyond frame");

  a_r8_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && a_mux != 2'd0) |-> (com_lvl[7:6] == com_lvl[3:2]))
    else $error("R8 COM3 differs from COM1");

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !ref_tick) |=> $stable(slot))
    else $error("R9 slot moved without tick");

  a_r11_frame_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != 3'd0) |-> $stable({a_mux, a_half, a_inv}))
    else $error("R11 config changed mid-frame");
endmodule

// File: tb/test_lcd_drive_seq.sv
module test_lcd_drive_seq;
  localparam int SEGS = 40;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, disp_en = 1'b0;
  logic [1:0] mux_sel = '0, frame_rate = '0, blink_rate = '0;
  logic half_bias = 1'b0, frame_inv = 1'b0;
  logic [4*SEGS-1:0] pix = '0;
  logic [7:0] com_lvl;
  logic [2*SEGS-1:0] seg_lvl;

  always #2 clk = ~clk;

  lcd_drive_seq i_lcd_drive_seq (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .disp_en(disp_en),
    .mux_sel(mux_sel), .half_bias(half_bias), .frame_inv(frame_inv),
    .frame_rate(frame_rate), .blink_rate(blink_rate), .pix(pix),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl));

  typedef struct {
    string tag;
    logic [7:0] com;
    logic [2*SEGS-1:0] seg;
  } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_slot = 0, m_acc = 0, m_blink = 0, m_mux = 0;
  bit m_half = 0, m_inv = 0;

  function automatic int nof(int m);
    return (m == 0) ? 4 : (m == 1) ? 3 : (m == 2) ? 2 : 1;
  endfunction

  function automatic logic [1:0] lv(int c, bit ng, bit hb);
    if (!ng) return 2'(c);
    if (hb && c == 1) return 2'd1;
    return 2'(3 - c);
  endfunction

  task automatic cyc(string tag, bit tick);
    item_t it;
    int n, sel, l, c, br;
    bit ng, stat, hb, blank;
    ref_tick = tick;
    if (!disp_en) begin
      m_slot = 0; m_acc = 0; m_blink = 0;
      m_mux = int'(mux_sel); m_half = half_bias; m_inv = frame_inv;
    end else if (tick) begin
      n = nof(m_mux);
      m_blink = (m_blink + 1) % 4096;
      m_acc = m_acc + (int'(frame_rate) + 1) * n;
      if (m_acc >= 32) begin
        m_acc -= 32;
        if (m_slot == 2*n - 1) begin
          m_slot = 0;
          m_mux = int'(mux_sel); m_half = half_bias; m_inv = frame_inv;
        end else m_slot++;
      end
    end
    it.tag = tag; it.com = '0; it.seg = '0;
    if (disp_en) begin
      n = nof(m_mux);
      if (m_inv) begin sel = m_slot % n; ng = (m_slot >= n); end
      else begin sel = m_slot / 2; ng = (m_slot % 2) == 1; end
      stat = (m_mux == 3); hb = m_half && !stat;
      br = int'(blink_rate);
      blank = (br != 0) && (((m_blink >> (12 - br)) & 1) == 1);
      for (int p = 0; p < 4; p++) begin
        l = (m_mux == 0) ? p : (m_mux == 1) ? ((p == 3) ? 1 : p) : (m_mux == 2) ? p % 2 : 0;
        it.com[2*p +: 2] = lv((l == sel) ? 3 : 1, ng, hb);
      end
      for (int s = 0; s < SEGS; s++) begin
        c = (pix[sel*SEGS + s] && !blank) ? 0 : (stat ? 3 : (hb ? 1 : 2));
        it.seg[2*s +: 2] = lv(c, ng, hb);
      end
    end
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic run(string tag, int cycles, int tick_every);
    for (int i = 0; i < cycles; i++) cyc(tag, (i % tick_every) == 0);
  endtask

  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_cmp++;
      if (com_lvl !== it.com || seg_lvl !== it.seg) begin
        n_bad++;
        $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h",
                 it.tag, com_lvl, seg_lvl, it.com, it.seg);
      end
    end
  end

  localparam logic [4*SEGS-1:0] PAT_A =
    {40'hA53C0FF096, 40'h123456789A, 40'hFF00FF0081, 40'h01807EE755};
  localparam logic [4*SEGS-1:0] PAT_B =
    {40'h0F0F0F0F0F, 40'hC3C3C3C3C3, 40'h5555555555, 40'hFFFFFFFFFF};

  initial begin
    pix = PAT_A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run("R1 reset/disabled", 6, 1);
    disp_en = 1'b1; frame_rate = 2'd3;
    run("R2 R5 R6 R9 third bias line inversion", 40, 1);
    frame_rate = 2'd0;
    run("R9 slow frame sparse ticks", 100, 2);
    frame_rate = 2'd3; half_bias = 1'b1;
    run("R3 R11 half bias from frame boundary", 80, 1);
    frame_inv = 1'b1;
    run("R7 R11 frame inversion", 80, 1);
    half_bias = 1'b0;
    run("R7 third bias frame inversion", 40, 1);
    mux_sel = 2'd1; frame_rate = 2'd2; frame_inv = 1'b0;
    run("R6 R8 three backplanes", 100, 1);
    mux_sel = 2'd2;
    run("R6 R8 two backplanes", 100, 1);
    mux_sel = 2'd3; half_bias = 1'b1;
    run("R4 R8 static ignores bias", 60, 1);
    mux_sel = 2'd0; half_bias = 1'b0; frame_rate = 2'd3;
    run("R11 back to four rows", 20, 3);
    pix = PAT_B;
    run("R5 new data pattern", 40, 1);
    disp_en = 1'b0;
    run("R1 disable resets timing", 3, 1);
    disp_en = 1'b1; blink_rate = 2'd3;
    run("R10 blink 2 Hz", 1200, 1);
    disp_en = 1'b0;
    run("R1 disabled between blinks", 2, 1);
    disp_en = 1'b1; blink_rate = 2'd1; frame_rate = 2'd1;
    run("R10 blink 0.5 Hz", 4300, 1);
    blink_rate = 2'd2;
    run("R10 blink 1 Hz", 200, 1);
    disp_en = 1'b0;
    run("R1 disabled at end", 5, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule